// File: doc/BRIEF.md
# Central Interrupt Control and Status

This block keeps the central interrupt control state of a small processor core. It holds one control byte with a counter enable, a top-level interrupt pending flag and enable, the global interrupt enable, the arbitration mode and the current priority level. It also holds a per-line edge polarity byte and a byte of sticky pending flags for eight external interrupt lines. Software reaches all three bytes through a byte-wide register port. Writes land on the next clock edge and reads are combinational.

The core reports its own events on single-cycle strobes: normal interrupt entry, top-level entry, return (flagged as top-level or normal), enable and disable. The block raises a top-level request from the pending flag. That request may bypass the global enable when the top-level enable bit and an external non-maskable select input are both high. In nested mode the core can load the priority level directly. Every trigger input passes through a two-flop synchronizer before its edge is detected. Priority arbitration, vector fetch and stacking are handled outside this block.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, the control byte (address 0) reads 0x87, the polarity byte (address 1) reads 0x00 and the pending byte (address 2) reads 0x00. The control byte fields are: bit7 counter enable (`cnt_en_o`), bit6 top-level pending, bit5 top-level enable, bit4 global enable (`gie_o`), bit3 arbitration mode (`nested_o`), bits2:0 priority level (`cpl_o`).
- R2: A synchronized rising edge on `tl_trig_i` sets the top-level pending bit. `ev_tl_ack_i` clears it. A register write sets or clears it. A trigger edge wins over an acknowledge or a write in the same cycle.
- R3: `tl_req_o` is high exactly when the top-level pending bit is 1 and either the global enable is 1 or both the top-level enable bit and `nmi_sel_i` are 1.
- R4: `ev_ack_i` and `ev_di_i` clear the global enable. `ev_ei_i`, and `ev_ret_i` with `ev_ret_tl_i` low, set it. `ev_tl_ack_i`, and `ev_ret_i` with `ev_ret_tl_i` high, leave it unchanged. When a clearing event and a setting event coincide, the clearing event wins.
- R5: Bit3 of the control byte drives `nested_o`: 0 selects concurrent mode, 1 selects nested mode.
- R6: `cpl_ld_i` loads `cpl_val_i` into the priority level only while nested mode is set. In concurrent mode it has no effect. A load wins over a write to the same field.
- R7: Polarity bit k selects the active edge of `ext_irq_i[k]`: 1 selects rising, 0 selects falling. An edge of the other direction does not set the pending bit.
- R8: An input change that occurs before clock edge 1 sets pending bit k at clock edge 3 and not earlier, because the path is two synchronizer flops plus one edge register.
- R9: External pending bits are sticky. Writing 1 to a bit at address 2 clears it and writing 0 has no effect. A hardware set in the same cycle as a clearing write leaves the bit at 1.
- R10: Register writes take effect at the next clock edge. A core event that changes the global enable overrides a simultaneous write to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register select: 0 control, 1 polarity, 2 pending |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| tl_trig_i | input | 1 | Top-level trigger, asynchronous, active on rising edge |
| ext_irq_i | input | 8 | External interrupt lines, asynchronous |
| nmi_sel_i | input | 1 | Lets the top-level enable bypass the global enable |
| ev_ack_i | input | 1 | Normal interrupt entry strobe |
| ev_tl_ack_i | input | 1 | Top-level interrupt entry strobe |
| ev_ret_i | input | 1 | Return-from-interrupt strobe |
| ev_ret_tl_i | input | 1 | Qualifies `ev_ret_i` as a top-level return |
| ev_ei_i | input | 1 | Enable-interrupts strobe |
| ev_di_i | input | 1 | Disable-interrupts strobe |
| cpl_ld_i | input | 1 | Priority level load (nested mode only) |
| cpl_val_i | input | 3 | Priority level to load |
| tl_req_o | output | 1 | Top-level interrupt request |
| gie_o | output | 1 | Global interrupt enable |
| nested_o | output | 1 | Arbitration mode, 1 = nested |
| cpl_o | output | 3 | Current priority level, 0 highest |
| cnt_en_o | output | 1 | Counter enable bit |
| ext_pend_o | output | 8 | External pending flags |

## Verification
The assertions check the following on every cycle:
- the entry and disable strobes always leave the global enable cleared;
- a top-level acknowledge with no new edge clears the pending flag;
- the request never appears without a pending flag, and never while the enable and the bypass are both off;
- the priority level does not move without a load or a write;
- a detected external edge is never lost to a clearing write.

Only the bench scenarios can show the rest. These are the exact three-edge latency of the synchronizer path, the choice of edge direction for each polarity bit, the full truth table of the request across the enable, bypass and pending combinations, and the precedence of core events over software writes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DW        = 8;
  localparam int unsigned AW        = 2;
  localparam int unsigned NEXT      = 8;
  localparam int unsigned SYNC_N    = 2;
  localparam int unsigned CPLW      = 3;

  localparam logic [AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [AW-1:0] ADDR_POL  = 2'd1;
  localparam logic [AW-1:0] ADDR_PEND = 2'd2;

  typedef struct packed {
    logic            cnt_en;
    logic            tl_pend;
    logic            tl_en;
    logic            gie;
    logic            nested;
    logic [CPLW-1:0] cpl;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{cnt_en: 1'b1, tl_pend: 1'b0, tl_en: 1'b0,
                                 gie: 1'b0, nested: 1'b0, cpl: 3'd7};
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] edge_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    prev_d = stage_q[LAST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
      prev_q <= prev_d;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_edge
    assign edge_o[k] = rise_sel_i[k] ? ( stage_q[LAST][k] & ~prev_q[k])
                                     : (~stage_q[LAST][k] &  prev_q[k]);
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            tl_edge_i,
  input  logic            nmi_sel_i,
  input  logic            ev_ack_i,
  input  logic            ev_tl_ack_i,
  input  logic            ev_ret_i,
  input  logic            ev_ret_tl_i,
  input  logic            ev_ei_i,
  input  logic            ev_di_i,
  input  logic            cpl_ld_i,
  input  logic [CPLW-1:0] cpl_val_i,
  output ctrl_t           ctrl_o,
  output logic            tl_req_o
);
  ctrl_t ctrl_q, ctrl_d;
  ctrl_t wr_view;
  logic  gie_set, gie_clr;

  assign wr_view = ctrl_t'(wdata_i);
  assign gie_set = ev_ei_i | (ev_ret_i & ~ev_ret_tl_i);
  assign gie_clr = ev_di_i | ev_ack_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) ctrl_d = wr_view;
    if (ev_tl_ack_i) ctrl_d.tl_pend = 1'b0;
    if (tl_edge_i)   ctrl_d.tl_pend = 1'b1;
    if (gie_set)     ctrl_d.gie = 1'b1;
    if (gie_clr)     ctrl_d.gie = 1'b0;
    if (cpl_ld_i && ctrl_q.nested) ctrl_d.cpl = cpl_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o   = ctrl_q;
  assign tl_req_o = ctrl_q.tl_pend & (ctrl_q.gie | (ctrl_q.tl_en & nmi_sel_i));

  // R2: acknowledge without a coincident edge leaves the flag cleared
  p_ack_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_tl_ack_i && !tl_edge_i) |=> !ctrl_q.tl_pend);
  // R2: a trigger edge always leaves the flag set
  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_edge_i |=> ctrl_q.tl_pend);
  // R4: entry and disable strobes always clear the enable
  p_clear_gie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_ack_i || ev_di_i) |=> !ctrl_q.gie);
  // R4: top-level entry/return alone do not move the enable
  p_tl_keeps_gie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_tl_ack_i || (ev_ret_i && ev_ret_tl_i)) && !ev_ack_i && !ev_di_i &&
     !ev_ei_i && !wr_en_i) |=> $stable(ctrl_q.gie));
  // R6: priority level only moves on a load or a write
  p_cpl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !cpl_ld_i) |=> $stable(ctrl_q.cpl));
  // R6: load ignored in concurrent mode
  p_cpl_conc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !ctrl_q.nested) |=> $stable(ctrl_q.cpl));
endmodule

// File: rtl/irq_ext_pend.sv
module irq_ext_pend
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = NEXT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_pol_i,
  input  logic         wr_pend_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] edge_i,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pol_q, pol_d, pend_q, pend_d, clr_v;

  assign clr_v = wr_pend_i ? wdata_i : '0;

  always_comb begin
    pol_d  = wr_pol_i ? wdata_i : pol_q;
    pend_d = (pend_q & ~clr_v) | edge_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_pol_i) pol_q <= pol_d;
      pend_q <= pend_d;
    end
  end

  assign pol_o  = pol_q;
  assign pend_o = pend_q;

  // R9: a detected edge is never lost to a clearing write
  p_hw_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != '0) |=> ((pend_q & $past(edge_i)) == $past(edge_i)));
  // R9: without edges or a write, pending bits never rise
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
  import irq_ctrl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic            reg_wr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            tl_trig_i,
  input  logic [NEXT-1:0] ext_irq_i,
  input  logic            nmi_sel_i,
  input  logic            ev_ack_i,
  input  logic            ev_tl_ack_i,
  input  logic            ev_ret_i,
  input  logic            ev_ret_tl_i,
  input  logic            ev_ei_i,
  input  logic            ev_di_i,
  input  logic            cpl_ld_i,
  input  logic [CPLW-1:0] cpl_val_i,
  output logic            tl_req_o,
  output logic            gie_o,
  output logic            nested_o,
  output logic [CPLW-1:0] cpl_o,
  output logic            cnt_en_o,
  output logic [NEXT-1:0] ext_pend_o
);
  ctrl_t           ctrl;
  logic            wr_ctrl, wr_pol, wr_pend;
  logic            tl_edge;
  logic [NEXT-1:0] ext_edge, pol;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign wr_pol  = reg_wr_i && (reg_addr_i == ADDR_POL);
  assign wr_pend = reg_wr_i && (reg_addr_i == ADDR_PEND);

  irq_sync_edge #(.W(1), .STAGES(SYNC_N)) u_tl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tl_trig_i),
    .rise_sel_i(1'b1), .edge_o(tl_edge));

  irq_sync_edge #(.W(NEXT), .STAGES(SYNC_N)) u_ext_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_irq_i),
    .rise_sel_i(pol), .edge_o(ext_edge));

  irq_ctrl_reg u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_ctrl), .wdata_i(reg_wdata_i),
    .tl_edge_i(tl_edge), .nmi_sel_i(nmi_sel_i), .ev_ack_i(ev_ack_i),
    .ev_tl_ack_i(ev_tl_ack_i), .ev_ret_i(ev_ret_i), .ev_ret_tl_i(ev_ret_tl_i),
    .ev_ei_i(ev_ei_i), .ev_di_i(ev_di_i), .cpl_ld_i(cpl_ld_i),
    .cpl_val_i(cpl_val_i), .ctrl_o(ctrl), .tl_req_o(tl_req_o));

  irq_ext_pend #(.W(NEXT)) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_pol_i(wr_pol), .wr_pend_i(wr_pend),
    .wdata_i(reg_wdata_i[NEXT-1:0]), .edge_i(ext_edge),
    .pol_o(pol), .pend_o(ext_pend_o));

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = DW'(ctrl);
      ADDR_POL:  reg_rdata_o = DW'(pol);
      ADDR_PEND: reg_rdata_o = DW'(ext_pend_o);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign gie_o    = ctrl.gie;
  assign nested_o = ctrl.nested;
  assign cpl_o    = ctrl.cpl;
  assign cnt_en_o = ctrl.cnt_en;

  // R3: no request without a pending flag
  p_req_needs_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tl_req_o |-> ctrl.tl_pend);
  // R3: no request when both the enable and the bypass are off
  p_req_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.gie && !(ctrl.tl_en && nmi_sel_i)) |-> !tl_req_o);
endmodule

// File: tb/irq_ctrl_core_bench.sv
module irq_ctrl_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tl_trig = 1'b0;
  logic [7:0] ext = '0;
  logic       nmi = 1'b0;
  logic       ack = 1'b0, tack = 1'b0, ret = 1'b0, ret_tl = 1'b0, ei = 1'b0, di = 1'b0;
  logic       cld = 1'b0;
  logic [2:0] cval = '0;
  logic       tl_req, gie, nested, cnt_en;
  logic [2:0] cpl;
  logic [7:0] pend;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  irq_ctrl_core u_irq_ctrl_core (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tl_trig_i(tl_trig),
    .ext_irq_i(ext), .nmi_sel_i(nmi), .ev_ack_i(ack), .ev_tl_ack_i(tack),
    .ev_ret_i(ret), .ev_ret_tl_i(ret_tl), .ev_ei_i(ei), .ev_di_i(di),
    .cpl_ld_i(cld), .cpl_val_i(cval), .tl_req_o(tl_req), .gie_o(gie),
    .nested_o(nested), .cpl_o(cpl), .cnt_en_o(cnt_en), .ext_pend_o(pend));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc(1);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  logic [7:0] v;

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset values
    rd_reg(2'd0, v); check("R1 ctrl", v, 8'h87);
    rd_reg(2'd1, v); check("R1 pol", v, 8'h00);
    rd_reg(2'd2, v); check("R1 pend", v, 8'h00);
    check("R1 outputs", {cnt_en, nested, gie, tl_req, 1'b0, cpl}, {4'b1000, 1'b0, 3'd7});

    // R10 write lands next edge; R5 mode bit; R10 counter enable bit
    addr = 2'd0; wdata = 8'h08; wr = 1'b1; #1;
    check("R10 before edge", {7'b0, nested}, 8'h00);
    cyc(1); wr = 1'b0;
    check("R5 nested", {cnt_en, nested, 6'b0}, 8'h40);
    wr_reg(2'd0, 8'h87);
    check("R5 concurrent", {7'b0, nested}, 8'h00);

    // R3 sweep over pending, top enable, global enable, bypass select
    for (int c = 0; c < 16; c++) begin
      logic p, te, g, n;
      {p, te, g, n} = 4'(c);
      nmi = n;
      wr_reg(2'd0, {1'b1, p, te, g, 4'b0111});
      check("R3 request", {7'b0, tl_req}, {7'b0, p & (g | (te & n))});
    end
    nmi = 1'b0;
    wr_reg(2'd0, 8'h87);

    // R2 trigger path, ack, and trigger over ack
    tl_trig = 1'b1; cyc(3);
    rd_reg(2'd0, v); check("R2 trigger sets", {7'b0, v[6]}, 8'h01);
    tack = 1'b1; cyc(1); tack = 1'b0;
    rd_reg(2'd0, v); check("R2 ack clears", {7'b0, v[6]}, 8'h00);
    tl_trig = 1'b0; cyc(3);
    tl_trig = 1'b1; cyc(2);          // edge detected during next cycle
    tack = 1'b1; cyc(1); tack = 1'b0;
    rd_reg(2'd0, v); check("R2 trigger beats ack", {7'b0, v[6]}, 8'h01);
    tl_trig = 1'b0;
    wr_reg(2'd0, 8'h87);
    rd_reg(2'd0, v); check("R2 write clears", {7'b0, v[6]}, 8'h00);
    wr_reg(2'd0, 8'hC7);
    rd_reg(2'd0, v); check("R2 software set", {7'b0, v[6]}, 8'h01);
    wr_reg(2'd0, 8'h87);

    // R4 event effects on the global enable
    ei = 1'b1; cyc(1); ei = 1'b0; check("R4 ei sets", {7'b0, gie}, 8'h01);
    tack = 1'b1; cyc(1); tack = 1'b0; check("R4 tl entry keeps", {7'b0, gie}, 8'h01);
    ack = 1'b1; cyc(1); ack = 1'b0; check("R4 ack clears", {7'b0, gie}, 8'h00);
    ret = 1'b1; ret_tl = 1'b1; cyc(1); ret = 1'b0; ret_tl = 1'b0;
    check("R4 tl return keeps", {7'b0, gie}, 8'h00);
    ret = 1'b1; cyc(1); ret = 1'b0; check("R4 return sets", {7'b0, gie}, 8'h01);
    di = 1'b1; cyc(1); di = 1'b0; check("R4 di clears", {7'b0, gie}, 8'h00);
    ei = 1'b1; di = 1'b1; cyc(1); ei = 1'b0; di = 1'b0;
    check("R4 clear wins", {7'b0, gie}, 8'h00);
    // R10 event overrides write
    addr = 2'd0; wdata = 8'h97; wr = 1'b1; di = 1'b1; cyc(1); wr = 1'b0; di = 1'b0;
    check("R10 di over write", {7'b0, gie}, 8'h00);
    addr = 2'd0; wdata = 8'h87; wr = 1'b1; ei = 1'b1; cyc(1); wr = 1'b0; ei = 1'b0;
    check("R10 ei over write", {7'b0, gie}, 8'h01);
    wr_reg(2'd0, 8'h87);

    // R6 priority load, ignored in concurrent mode, applied in nested mode
    for (int l = 0; l < 8; l++) begin
      cval = 3'(l); cld = 1'b1; cyc(1); cld = 1'b0;
      check("R6 concurrent ignore", {5'b0, cpl}, 8'd7);
    end
    wr_reg(2'd0, 8'h8F);
    for (int l = 0; l < 8; l++) begin
      cval = 3'(l); cld = 1'b1; cyc(1); cld = 1'b0;
      check("R6 nested load", {5'b0, cpl}, 8'(l));
    end
    addr = 2'd0; wdata = 8'h8A; wr = 1'b1; cval = 3'd5; cld = 1'b1; cyc(1);
    wr = 1'b0; cld = 1'b0;
    check("R6 load over write", {5'b0, cpl}, 8'd5);
    wr_reg(2'd0, 8'h87);

    // R7 per-line polarity sweep
    for (int k = 0; k < 8; k++) begin
      for (int pl = 0; pl < 2; pl++) begin
        logic [7:0] m;
        m = 8'(1) << k;
        wr_reg(2'd1, pl[0] ? m : 8'h00);
        ext[k] = 1'b1; cyc(4);
        check("R7 rising", pend, pl[0] ? m : 8'h00);
        wr_reg(2'd2, 8'hFF);
        ext[k] = 1'b0; cyc(4);
        check("R7 falling", pend, pl[0] ? 8'h00 : m);
        wr_reg(2'd2, 8'hFF);
      end
    end

    // R8 latency, R9 sticky, write-zero, clear, and collision
    wr_reg(2'd1, 8'hFF);
    ext[3] = 1'b1; cyc(2);
    check("R8 not after two edges", pend, 8'h00);
    cyc(1);
    check("R8 set at third edge", pend, 8'h08);
    ext[3] = 1'b0; cyc(4);
    check("R9 sticky", pend, 8'h08);
    wr_reg(2'd2, 8'h00);
    check("R9 write zero no effect", pend, 8'h08);
    wr_reg(2'd2, 8'h08);
    check("R9 write one clears", pend, 8'h00);
    ext[5] = 1'b1; cyc(4);
    check("R9 set again", pend, 8'h20);
    ext[5] = 1'b0; cyc(4);
    ext[5] = 1'b1; cyc(2);
    addr = 2'd2; wdata = 8'h20; wr = 1'b1; cyc(1); wr = 1'b0;
    check("R9 hw set beats clear", pend, 8'h20);
    ext[5] = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule